// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a synchronous request port and an external 32K x 8 asynchronous static RAM. The memory has no clock, so every access needs a timed pattern of strobes. A host presents one request at a time with a valid/ready handshake. A request is a read or a write, a 15-bit word address and, for a write, one byte. The block then plays out the strobe pattern for that request. On the memory side it drives the three active-low strobes (chip select, output enable, write strobe), the address, and the controller half of the shared byte-wide data bus. That half is an output value with a separate drive-enable. The bus can then be resolved by a pad tri-state, or by a mux in simulation.

Each memory timing minimum is given in nanoseconds. It becomes a whole number of clock cycles, rounded up with the clock period as divisor. A small down-counter holds each phase for its count. A read holds chip select and output enable low until the access time has passed. The byte on the bus is latched at the same edge that raises the strobes, and a one-cycle response pulse follows.

A write keeps output enable high the whole time. It first waits out the time the memory takes to release the bus. Only then does it drop the write strobe and turn on its own data drivers. Chip select and the write strobe rise together to end the write. The data drivers stay on for one more cycle to give data hold.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, all three strobes are high, the data drivers are off and the response pulse is low. Ready is low during reset and rises at the first clock edge after reset falls.
- R2: A request is taken at a rising edge where valid and ready are both high. Ready then stays low until the operation has finished: 4 cycles for a read and 5 cycles for a write at the default timing. Ready is high only while chip select is high. A request held while ready is low is not taken early.
- R3: A read drives chip select and output enable low, with the write strobe high, for exactly 3 cycles at the default timing. These cycles begin in the cycle after acceptance.
- R4: The read byte is the bus value in the last access cycle. It appears on the read-data output together with a response pulse that lasts one cycle. That cycle is the one right after the access cycles. The byte equals the last value written to that address, or 0 if the address was never written.
- R5: A write holds chip select low for 4 cycles at the default timing. The write strobe is low only in the last 2 of those cycles. Both strobes rise at the same edge, which ends the write.
- R6: Output enable stays high for the whole of a write. The controller data drivers turn on in the first cycle the write strobe is low. They stay on for one cycle after the write ends, and the driven byte does not change while they are on.
- R7: The controller never drives the bus while output enable is low. It never drives the bus during the 2 cycles after output enable rises, which is the memory's bus release time at the default timing.
- R8: While chip select is low, the memory address equals the address of the accepted request and does not change.
- R9: Address and write data are taken at acceptance. Changes on the request inputs after that have no effect on the memory address or on the driven byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse when read data is valid |
| rsp_rdata | output | 8 | Captured read byte |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | 15 | Memory address |
| mem_dq_o | output | 8 | Byte the controller drives onto the bus |
| mem_dq_oe | output | 1 | Controller bus drive enable |
| mem_dq_i | input | 8 | Byte read back from the bus |

## Verification
The risky overlap is between two things that can happen in the same cycle. One is the memory still driving the bus after a read ends, because its outputs release slowly. The other is the controller turning on its own drivers for a write that follows. The bench provokes this by holding the next request valid while a read is still running, so a write starts as soon as ready returns. The bench's memory model keeps driving for two cycles after output enable rises, and it flags any cycle in which both sides drive. Capture timing is judged the same way: the model offers a junk byte until the third access cycle, so latching one cycle early returns the wrong data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_RD_CAPTURE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER
  } seq_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // whole cycles covering a nanosecond minimum, never less than one
  function automatic int ns_to_cycles(input int ns, input int period_ns);
    return imax(1, (ns + period_ns - 1) / period_ns);
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign last = (cnt == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W     = 2,
  parameter int RD_CYC    = 3,
  parameter int TURN_CYC  = 2,
  parameter int PULSE_CYC = 2,
  parameter int RD_REC    = 1,
  parameter int WR_REC    = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_last,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             ready,
  output logic             rsp_valid,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             drive
);

  seq_state_t state;
  logic       phase_end;

  assign accept    = (state == ST_IDLE) && ready && req_valid;
  assign phase_end = (state != ST_IDLE) && tmr_last;
  assign capture   = (state == ST_RD_ACCESS) && tmr_last;
  assign tmr_load  = accept || phase_end;

  always_comb begin
    tmr_val = '0;
    if (accept) begin
      tmr_val = req_write ? CNT_W'(TURN_CYC - 1) : CNT_W'(RD_CYC - 1);
    end else begin
      case (state)
        ST_RD_ACCESS: tmr_val = CNT_W'(RD_REC - 1);
        ST_WR_SETUP:  tmr_val = CNT_W'(PULSE_CYC - 1);
        ST_WR_PULSE:  tmr_val = CNT_W'(WR_REC - 1);
        default:      tmr_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ready     <= 1'b0;
      rsp_valid <= 1'b0;
      ce_n      <= 1'b1;
      oe_n      <= 1'b1;
      we_n      <= 1'b1;
      drive     <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            ready <= 1'b0;
            ce_n  <= 1'b0;
            if (req_write) begin
              state <= ST_WR_SETUP;
            end else begin
              oe_n  <= 1'b0;
              state <= ST_RD_ACCESS;
            end
          end else begin
            ready <= 1'b1;
          end
        end
        ST_RD_ACCESS: if (tmr_last) begin
          ce_n      <= 1'b1;
          oe_n      <= 1'b1;
          rsp_valid <= 1'b1;
          state     <= ST_RD_CAPTURE;
        end
        ST_RD_CAPTURE: if (tmr_last) begin
          ready <= 1'b1;
          state <= ST_IDLE;
        end
        ST_WR_SETUP: if (tmr_last) begin
          we_n  <= 1'b0;
          drive <= 1'b1;
          state <= ST_WR_PULSE;
        end
        ST_WR_PULSE: if (tmr_last) begin
          we_n  <= 1'b1;
          ce_n  <= 1'b1;
          state <= ST_WR_RECOVER;
        end
        ST_WR_RECOVER: if (tmr_last) begin
          drive <= 1'b0;
          ready <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: handshake only offered with the memory deselected
  a_r2_ready_only_deselected: assert property (@(posedge clk) disable iff (rst)
    ready |-> ce_n);

  // R4: response lasts one cycle
  a_r4_rsp_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R5: write strobe only inside chip select
  a_r5_we_within_ce: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> !ce_n);

  // R6: output enable never low during a write pulse
  a_r6_oe_high_during_write: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> oe_n);

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      rsp_rdata <= '0;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        mem_dq_o <= req_wdata;
      end
      if (capture) begin
        rsp_rdata <= mem_dq_i;
      end
    end
  end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_RC_NS       = 12,
  parameter int T_AA_NS       = 12,
  parameter int T_DOE_NS      = 5,
  parameter int T_HZOE_NS     = 6,
  parameter int T_WC_NS       = 12,
  parameter int T_PWE_NS      = 8,
  parameter int T_SD_NS       = 6,
  parameter int T_AW_NS       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int RD_CYC    = ns_to_cycles(imax(T_AA_NS, T_DOE_NS), CLK_PERIOD_NS);
  localparam int TURN_CYC  = ns_to_cycles(T_HZOE_NS, CLK_PERIOD_NS);
  localparam int PULSE_CYC = ns_to_cycles(imax(T_PWE_NS, imax(T_SD_NS, T_AW_NS)),
                                          CLK_PERIOD_NS);
  localparam int CYC_MIN   = ns_to_cycles(imax(T_RC_NS, T_WC_NS), CLK_PERIOD_NS);
  localparam int RD_REC    = imax(1, CYC_MIN - RD_CYC);
  localparam int WR_REC    = imax(1, CYC_MIN - TURN_CYC - PULSE_CYC);
  localparam int MAX_CYC   = imax(imax(RD_CYC, TURN_CYC),
                                  imax(PULSE_CYC, imax(RD_REC, WR_REC)));
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_last;
  logic             accept;
  logic             capture;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  sram_seq_fsm #(
    .CNT_W     (CNT_W),
    .RD_CYC    (RD_CYC),
    .TURN_CYC  (TURN_CYC),
    .PULSE_CYC (PULSE_CYC),
    .RD_REC    (RD_REC),
    .WR_REC    (WR_REC)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .tmr_last  (tmr_last),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .accept    (accept),
    .capture   (capture),
    .ready     (req_ready),
    .rsp_valid (rsp_valid),
    .ce_n      (mem_ce_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .drive     (mem_dq_oe)
  );

  sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_dq_i  (mem_dq_i),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .rsp_rdata (rsp_rdata)
  );

  // R1: quiet memory side right after reset
  a_r1_reset_strobes_high: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid));

  // R7: never fight the memory's output drivers
  a_r7_no_bus_fight: assert property (@(posedge clk) disable iff (rst)
    !(mem_dq_oe && !mem_oe_n));

  // R8: address frozen while selected
  a_r8_addr_held: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  // R9: driven byte frozen while drivers on
  a_r9_wdata_held: assert property (@(posedge clk) disable iff (rst)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o));

endmodule

// File: tb/test_sram_strobe_ctrl.sv
module test_sram_strobe_ctrl;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready, req_write;
  logic [14:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        mem_ce_n, mem_oe_n, mem_we_n;
  logic [14:0] mem_addr;
  logic [7:0]  mem_dq_o;
  logic        mem_dq_oe;
  logic [7:0]  mem_dq_i;

  always #2 clk = ~clk;

  sram_strobe_ctrl i_sram_strobe_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  typedef struct packed {
    logic        ce, oe, we, drv, rdy, rv, is_wr;
    logic [3:0]  tag;
    logic [14:0] addr;
    logic [7:0]  wd, rd;
  } exp_t;

  exp_t exp_q[$];
  exp_t e;
  logic [7:0] ref_mem [int];
  logic [7:0] ram_arr [int];

  int checks = 0, failures = 0;
  bit run = 0, finished = 0;
  bit en_now, ram_drv = 0, wr_pend = 0;
  logic [7:0] ram_val = 8'h00, wr_d = 8'h00;
  int acc = 0, rel = 0, wr_a = 0;

  assign mem_dq_i = ram_drv ? ram_val : (mem_dq_oe ? mem_dq_o : 8'hEE);

  function automatic string tname(input int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [7:0] ref_get(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction

  function automatic logic [7:0] ram_get(input int a);
    return ram_arr.exists(a) ? ram_arr[a] : 8'h00;
  endfunction

  task automatic chk(input bit ok, input int t, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tname(t), what, act, expv, $time);
    end
  endtask

  function automatic exp_t mk(input logic ce, oe, we, drv, rdy, rv, wr,
                              input int t, input logic [14:0] a,
                              input logic [7:0] wd, rd);
    exp_t x;
    x.ce = ce; x.oe = oe; x.we = we; x.drv = drv; x.rdy = rdy; x.rv = rv;
    x.is_wr = wr; x.tag = 4'(t); x.addr = a; x.wd = wd; x.rd = rd;
    return x;
  endfunction

  // reference model: memory behaviour plus expected per-cycle port values
  always @(negedge clk) begin
    if (!rst && run) begin
      en_now = !mem_ce_n && !mem_oe_n && mem_we_n;
      // R7: memory drives while read-enabled and 2 cycles after release
      chk(!((en_now || rel > 0) && mem_dq_oe), 7, "bus contention", int'(mem_dq_oe), 0);
      if (!mem_ce_n && !mem_we_n) begin
        wr_pend = 1; wr_a = int'(mem_addr);
        wr_d = mem_dq_oe ? mem_dq_o : 8'hEE;
      end else if (wr_pend) begin
        ram_arr[wr_a] = wr_d; wr_pend = 0;
      end
      if (en_now) begin acc++; rel = 2; end
      else begin acc = 0; if (rel > 0) rel--; end
      ram_drv = en_now && (acc >= 3);
      ram_val = ram_drv ? ram_get(int'(mem_addr)) : 8'hEE;

      e = (exp_q.size() > 0) ? exp_q.pop_front()
                             : mk(1, 1, 1, 0, 1, 0, 0, 2, 15'd0, 8'd0, 8'd0);
      chk(mem_ce_n == e.ce, int'(e.tag), "chip select", int'(mem_ce_n), int'(e.ce));
      chk(mem_we_n == e.we, int'(e.tag), "write strobe", int'(mem_we_n), int'(e.we));
      chk(mem_oe_n == e.oe, e.is_wr ? 6 : int'(e.tag), "output enable", int'(mem_oe_n), int'(e.oe));
      chk(mem_dq_oe == e.drv, e.is_wr ? 6 : int'(e.tag), "drive enable", int'(mem_dq_oe), int'(e.drv));
      chk(req_ready == e.rdy, 2, "ready", int'(req_ready), int'(e.rdy));  // R2
      chk(rsp_valid == e.rv, 4, "response pulse", int'(rsp_valid), int'(e.rv));
      if (!e.ce) chk(mem_addr == e.addr, 8, "address", int'(mem_addr), int'(e.addr));
      if (e.drv) chk(mem_dq_o == e.wd, 9, "driven byte", int'(mem_dq_o), int'(e.wd));
      if (e.rv) chk(rsp_rdata == e.rd, 4, "read byte", int'(rsp_rdata), int'(e.rd));

      if (req_valid && req_ready) begin
        if (req_write) begin
          ref_mem[int'(req_addr)] = req_wdata;
          // R5: 2 setup cycles, 2 strobe cycles; R6: 1 hold cycle with drivers on
          for (int j = 0; j < 2; j++) exp_q.push_back(mk(0, 1, 1, 0, 0, 0, 1, 5, req_addr, req_wdata, 8'd0));
          for (int j = 0; j < 2; j++) exp_q.push_back(mk(0, 1, 0, 1, 0, 0, 1, 5, req_addr, req_wdata, 8'd0));
          exp_q.push_back(mk(1, 1, 1, 1, 0, 0, 1, 6, req_addr, req_wdata, 8'd0));
        end else begin
          // R3: 3 access cycles; R4: response in the following cycle
          for (int j = 0; j < 3; j++) exp_q.push_back(mk(0, 0, 1, 0, 0, 0, 0, 3, req_addr, 8'd0, 8'd0));
          exp_q.push_back(mk(1, 1, 1, 0, 0, 1, 0, 4, req_addr, 8'd0, ref_get(int'(req_addr))));
        end
      end
    end
  end

  // valid asserted at once and held while busy (R2); inputs scrambled after acceptance (R9)
  task automatic do_op(input bit wr, input logic [14:0] a, input logic [7:0] d);
    bit got;
    @(posedge clk); #1;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    do begin
      @(negedge clk); got = req_ready;
      @(posedge clk);
    end while (!got);
    #1;
    req_valid = 0; req_addr = ~a; req_wdata = ~d; req_write = ~wr;
  endtask

  initial begin
    rst = 1; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(mem_ce_n && mem_oe_n && mem_we_n, 1, "strobes in reset", int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);
    chk(!mem_dq_oe, 1, "drivers in reset", int'(mem_dq_oe), 0);
    chk(!req_ready, 1, "ready in reset", int'(req_ready), 0);
    chk(!rsp_valid, 1, "response in reset", int'(rsp_valid), 0);
    @(posedge clk); #1;
    rst = 0;
    exp_q.push_back(mk(1, 1, 1, 0, 0, 0, 0, 1, 15'd0, 8'd0, 8'd0));
    run = 1;

    do_op(1, 15'h0000, 8'hA5);
    do_op(1, 15'h7FFF, 8'h3C);
    do_op(1, 15'h1234, 8'hFF);
    do_op(1, 15'h4321, 8'h00);
    do_op(0, 15'h0000, 8'h00);
    do_op(0, 15'h7FFF, 8'h00);
    do_op(0, 15'h1234, 8'h00);
    do_op(0, 15'h4321, 8'h00);
    do_op(0, 15'h0005, 8'h00);      // never written: reads 0
    do_op(1, 15'h1234, 8'h5A);      // write straight after a read: turnaround
    do_op(0, 15'h1234, 8'h00);      // read straight after a write
    for (int i = 0; i < 16; i++) begin
      do_op(1, 15'((i * 2053) & 32'h7FFF), 8'((i * 37) + 1));
      do_op(0, 15'((i * 2053) & 32'h7FFF), 8'h00);
    end
    for (int i = 0; i < 4; i++) do_op(0, 15'((i * 2053) & 32'h7FFF), 8'h00);

    repeat (12) @(posedge clk);
    chk(exp_q.size() == 0, 2, "pending expected cycles", exp_q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule